// File: doc/BRIEF.md
# Read Latency Data Pipeline

This block sits between the command side of a synchronous DRAM controller and the capture register on the read data bus. The command scheduler tells it when a read command goes out, the burst length of that read, and when it issues a burst stop or an output-mask request. The block expands each read into one beat per clock. It carries every beat through a short shift pipeline whose entry point depends on the programmed read latency (2 or 3 clocks). It raises a capture strobe in the clock period that ends with the edge on which the memory drives that beat's data. The captured 8-bit word then appears on a registered output together with a valid flag.

Each pipeline stage holds a valid bit and a cancel bit. A beat whose slot a stop request has claimed still moves through the pipeline but never raises the strobe. A beat whose data edge a mask request hits is blanked at the output, a fixed two clocks after the request, whatever the latency. A new read replaces what is left of the running burst on any cycle. A change to the latency setting takes effect only once nothing is in flight.

The data side is a valid-only stream. The memory cannot be stalled, so no ready input exists. The consumer must accept every word on the cycle `rd_valid` is high. `rd_data` holds its last captured value while `rd_valid` is low.

Top module: `rd_lat_align`

## Requirements
- R1: After reset, `rd_valid` stays low until a read command has been given and its latency has elapsed.
- R2: With latency 2 in force (`lat_sel`=0), a read accepted at clock edge t yields beat k (k from 0) with `rd_valid` high right after edge t+k+2, and `rd_data` equal to `dq_in` as sampled at that edge.
- R3: With latency 3 in force (`lat_sel`=1), beat k of a read accepted at edge t is captured at edge t+k+3, with the same data rule as R2.
- R4: `rd_blen` selects the beat count as 1 << `rd_blen` (0→1, 1→2, 2→4, 3→8). The beats of one read fall on consecutive edges, and back-to-back reads leave no gap between bursts.
- R5: A `mask_req` sampled at edge m suppresses the capture at edge m+2 at either latency, so `rd_valid` is low right after that edge. Other beats are unaffected.
- R6: A `stop_req` sampled at edge s with no read at that edge drops every beat of the current burst scheduled at edge s or later, so nothing is captured at edge s+L or afterwards. Beats issued before s still arrive. A stop while idle has no effect. A read at the same edge takes priority over a stop.
- R7: A read accepted while a burst is running discards the remaining beats of the old burst and starts its own beats at its own edge. This holds even when it comes one clock after the previous read.
- R8: `lat_sel` is taken into use only at an edge where no beat is in flight, no burst beats remain and no read is being accepted. A read issued while the pipeline is busy uses the latency already in force.
- R9: `rd_data` changes only at edges that also raise `rd_valid`, and otherwise keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_sel | input | 1 | Requested read latency: 0 = 2 clocks, 1 = 3 clocks |
| rd_cmd | input | 1 | Read command issued at this edge |
| rd_blen | input | 2 | Burst length code for the read (beats = 1 << code) |
| stop_req | input | 1 | Burst stop or precharge issued at this edge |
| mask_req | input | 1 | Output mask request at this edge |
| dq_in | input | 8 | Read data bus from the memory |
| cap_en | output | 1 | High in the period whose closing edge captures a beat |
| rd_valid | output | 1 | Registered captured-word valid |
| rd_data | output | 8 | Registered captured word |

## Verification
The assertions assume that every command input is a known value at each rising edge after reset. They also assume that `rd_blen` matters only on edges where `rd_cmd` is high. The stimulus drives all inputs only on falling edges, from a quiet idle level, and gives every pulse a width of exactly one clock. Stop and mask pulses are always placed on edges that carry no read, so the read-versus-stop priority never needs arbitration in the model. Latency changes are requested both while idle and in the middle of a burst, so the hold rule is exercised from both sides.

// File: rtl/rla_pkg.sv
package rla_pkg;

  // One pipeline slot: a beat is present, and whether it was cancelled.
  typedef struct packed {
    logic vld;
    logic cxl;
  } rla_slot_t;

endpackage

// File: rtl/rla_burst_gen.sv
module rla_burst_gen #(
  parameter int BLEN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [BLEN_W-1:0] rd_blen,
  input  logic              stop_req,
  output logic              beat_vld,
  output logic              beat_cxl,
  output logic              gen_busy
);

  localparam int BL_MAX = 1 << ((1 << BLEN_W) - 1);
  localparam int CW     = $clog2(BL_MAX);

  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;
  logic [CW-1:0] load_v;

  always_comb begin
    load_v = CW'((1 << rd_blen) - 1);
  end

  // A read always produces a beat; otherwise the remaining count does.
  // A stop claims the current slot as cancelled and clears the rest.
  assign gen_busy = (left_q != '0);
  assign beat_vld = rd_cmd | gen_busy;
  assign beat_cxl = ~rd_cmd & stop_req & gen_busy;

  always_comb begin
    if (rd_cmd)         left_d = load_v;
    else if (stop_req)  left_d = '0;
    else if (gen_busy)  left_d = left_q - 1'b1;
    else                left_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  // R6
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !rd_cmd) |=> (left_q == '0));

  // R4
  beat_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_busy && !rd_cmd && !stop_req) |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/rla_lat_pipe.sv
module rla_lat_pipe
  import rla_pkg::*;
#(
  parameter int LAT_LO = 2,
  parameter int LAT_HI = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_sel,
  input  logic hold,
  input  logic ins_vld,
  input  logic ins_cxl,
  output logic tail_vld,
  output logic tail_cxl,
  output logic pipe_busy
);

  localparam int DEPTH     = LAT_HI;
  localparam int IW        = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SHORT_IDX = LAT_HI - LAT_LO;

  rla_slot_t stg [DEPTH];
  rla_slot_t nxt [DEPTH];
  rla_slot_t ins;
  logic      lat_hi_q;
  logic [IW-1:0] ins_idx;

  assign ins     = '{vld: ins_vld, cxl: ins_cxl};
  assign ins_idx = lat_hi_q ? IW'(0) : IW'(SHORT_IDX);

  // Shorter latency enters further down the chain; the tail is fixed.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = (ins_idx == IW'(0)) ? ins : '0;
    end else begin : g_body
      assign nxt[i] = (ins_idx == IW'(i)) ? ins : stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= nxt[i];
    end
  end

  always_comb begin
    pipe_busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) pipe_busy = pipe_busy | stg[i].vld;
  end

  // Latency setting is adopted only when nothing is or is about to be in flight.
  always_ff @(posedge clk) begin
    if (!rst_n)                   lat_hi_q <= 1'b0;
    else if (!pipe_busy && !hold) lat_hi_q <= lat_sel;
  end

  assign tail_vld = stg[DEPTH-1].vld;
  assign tail_cxl = stg[DEPTH-1].cxl;

  // R8
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_busy |=> $stable(lat_hi_q));

  // R2
  short_lat_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_hi_q |-> !stg[0].vld);

endmodule

// File: rtl/rla_mask_dly.sv
module rla_mask_dly #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_req,
  output logic mask_late
);

  logic [DLY-1:0] sr_q;

  if (DLY == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= mask_req;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[DLY-2:0], mask_req};
    end
  end

  assign mask_late = sr_q[DLY-1];

endmodule

// File: rtl/rd_lat_align.sv
module rd_lat_align #(
  parameter int DW     = 8,
  parameter int BLEN_W = 2,
  parameter int LAT_LO = 2,
  parameter int LAT_HI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_sel,
  input  logic              rd_cmd,
  input  logic [BLEN_W-1:0] rd_blen,
  input  logic              stop_req,
  input  logic              mask_req,
  input  logic [DW-1:0]     dq_in,
  output logic              cap_en,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);

  localparam int MASK_DLY = 2;

  logic beat_vld, beat_cxl, gen_busy;
  logic tail_vld, tail_cxl, pipe_busy;
  logic mask_late;

  rla_burst_gen #(.BLEN_W(BLEN_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cmd   (rd_cmd),
    .rd_blen  (rd_blen),
    .stop_req (stop_req),
    .beat_vld (beat_vld),
    .beat_cxl (beat_cxl),
    .gen_busy (gen_busy)
  );

  rla_lat_pipe #(.LAT_LO(LAT_LO), .LAT_HI(LAT_HI)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_sel   (lat_sel),
    .hold      (gen_busy | rd_cmd),
    .ins_vld   (beat_vld),
    .ins_cxl   (beat_cxl),
    .tail_vld  (tail_vld),
    .tail_cxl  (tail_cxl),
    .pipe_busy (pipe_busy)
  );

  rla_mask_dly #(.DLY(MASK_DLY)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_req  (mask_req),
    .mask_late (mask_late)
  );

  assign cap_en = tail_vld & ~tail_cxl & ~mask_late;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end

  // R5
  mask_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_req, 2) |-> !cap_en);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

endmodule

// File: tb/rd_lat_align_bench.sv
`timescale 1ns/1ps
module rd_lat_align_bench;

  localparam int NE = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lat_sel = 1'b0;
  logic       rd_cmd = 1'b0;
  logic [1:0] rd_blen = 2'd0;
  logic       stop_req = 1'b0;
  logic       mask_req = 1'b0;
  logic [7:0] dq_in = 8'd0;
  logic       cap_en;
  logic       rd_valid;
  logic [7:0] rd_data;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    beat_lat [NE];
  bit    masked   [NE];
  logic [7:0] last_data = 8'd0;

  rd_lat_align u_rd_lat_align (
    .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .rd_cmd(rd_cmd),
    .rd_blen(rd_blen), .stop_req(stop_req), .mask_req(mask_req),
    .dq_in(dq_in), .cap_en(cap_en), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input int e);
    return 8'((e * 29 + 7) & 255);
  endfunction

  // Memory drives a known word for every edge.
  always @(negedge clk) dq_in <= pat(cyc + 1);

  // Monitor: edge cyc has just passed; compare against requirement model.
  always @(negedge clk) begin
    if (!done) begin
      bit exp_v;
      exp_v = 1'b0;
      if (cyc >= 2 && cyc < NE && beat_lat[cyc-2] == 2) exp_v = 1'b1;
      if (cyc >= 3 && cyc < NE && beat_lat[cyc-3] == 3) exp_v = 1'b1;
      if (cyc < NE && masked[cyc]) exp_v = 1'b0;
      checks++;
      if (rd_valid !== exp_v || (exp_v && rd_data !== pat(cyc))) begin
        errors++;
        $display("FAIL %s edge %0d valid=%0b exp=%0b data=%h exp=%h",
                 cur_req, cyc, rd_valid, exp_v, rd_data, pat(cyc));
      end
      if (!exp_v) begin
        checks++;
        if (rd_data !== last_data) begin
          errors++;
          $display("FAIL R9 edge %0d data=%h exp=%h", cyc, rd_data, last_data);
        end
      end else begin
        last_data = pat(cyc);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] code, input int lat);
    int e;
    e = cyc + 1;
    for (int k = e; k < NE; k++) beat_lat[k] = 0;
    for (int k = 0; k < (1 << code); k++) beat_lat[e + k] = lat;
    rd_cmd  = 1'b1;
    rd_blen = code;
    @(negedge clk);
    rd_cmd  = 1'b0;
  endtask

  task automatic stop_now();
    int e;
    e = cyc + 1;
    for (int k = e; k < NE; k++) beat_lat[k] = 0;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic mask_now();
    masked[cyc + 3] = 1'b1;
    mask_req = 1'b1;
    @(negedge clk);
    mask_req = 1'b0;
  endtask

  task automatic set_lat(input logic s);
    lat_sel = s;
    idle(3);
  endtask

  initial begin
    for (int k = 0; k < NE; k++) begin
      beat_lat[k] = 0;
      masked[k]   = 1'b0;
    end
    idle(3);
    rst_n = 1'b1;
    // R1: quiet after reset
    cur_req = "R1";
    idle(6);

    // R2: latency 2 over every burst code
    cur_req = "R2";
    set_lat(1'b0);
    for (int c = 0; c < 4; c++) begin
      rd(2'(c), 2);
      idle(12);
    end

    // R3: latency 3 over every burst code
    cur_req = "R3";
    set_lat(1'b1);
    for (int c = 0; c < 4; c++) begin
      rd(2'(c), 3);
      idle(12);
    end

    // R4: gap-free back-to-back bursts at both latencies
    cur_req = "R4";
    for (int s = 0; s < 2; s++) begin
      set_lat(s[0]);
      rd(2'd3, s ? 3 : 2);
      idle(7);
      rd(2'd2, s ? 3 : 2);
      idle(12);
    end

    // R5: mask blanks the capture two edges later
    cur_req = "R5";
    for (int s = 0; s < 2; s++) begin
      set_lat(s[0]);
      rd(2'd3, s ? 3 : 2);
      idle(1);
      mask_now();
      idle(2);
      mask_now();
      idle(12);
    end

    // R6: stop mid-burst and stop while idle
    cur_req = "R6";
    for (int s = 0; s < 2; s++) begin
      set_lat(s[0]);
      rd(2'd3, s ? 3 : 2);
      idle(2);
      stop_now();
      idle(12);
    end
    stop_now();
    idle(6);

    // R7: interrupting reads, one clock apart and later
    cur_req = "R7";
    for (int s = 0; s < 2; s++) begin
      set_lat(s[0]);
      rd(2'd3, s ? 3 : 2);
      rd(2'd1, s ? 3 : 2);
      idle(1);
      rd(2'd2, s ? 3 : 2);
      idle(12);
    end

    // R8: latency change held while busy, adopted after drain
    cur_req = "R8";
    set_lat(1'b0);
    rd(2'd3, 2);
    lat_sel = 1'b1;
    idle(2);
    rd(2'd1, 2);
    idle(12);
    rd(2'd0, 3);
    idle(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired at edge %0d exp=finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule